// File: doc/BRIEF.md
# Dual-Lane ChaCha Quarter-Round Arithmetic Unit

This unit executes two custom instructions on a pair of 64-bit source operands. Each operand is treated as two separate 32-bit lanes, so two independent ChaCha quarter rounds can advance side by side through a single 64-bit datapath. One instruction adds the operands lane by lane. The other XORs them lane by lane and rotates each lane left by an amount that the instruction's funct7 field selects.

A core's decode stage presents `rs1`, `rs2` and `funct7` with a one-cycle `in_valid` strobe. The opcode and funct3 checks are done upstream. One cycle later the unit returns the 64-bit result, a valid flag and an illegal flag. funct7 codes outside the unit's range are reported as illegal and produce a zero result.

Top module: `chacha_lane_unit`

## Requirements
- R1: With funct7 = 24 (binary 0011000), result bits 31..0 equal (rs1[31:0] + rs2[31:0]) mod 2^32.
- R2: With funct7 = 24, result bits 63..32 equal (rs1[63:32] + rs2[63:32]) mod 2^32. A carry out of the low-lane sum never reaches the high lane.
- R3: With funct7 = 24 + k for k in 1..4, each lane equals rotl(rs1_lane XOR rs2_lane, n). The rotation n is 16 for k=1, 12 for k=2, 8 for k=3 and 7 for k=4.
- R4: For the XOR-rotate op, the high-lane result is placed in bits 63..32 and the low-lane result in bits 31..0.
- R5: A valid request with a funct7 outside 24..28 gives `out_illegal` = 1 and `out_result` = 0 in the following cycle.
- R6: `out_valid` is high in the cycle after a cycle in which `in_valid` is high, and low in the cycle after a cycle in which `in_valid` is low (one-cycle latency).
- R7: Synchronous active-high reset clears `out_valid`, `out_illegal` and `out_result` to 0.
- R8: When `in_valid` is low, `out_result` holds its previous value and `out_illegal` is 0 in the next cycle, whatever the operands or funct7 are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| rs1 | input | 64 | First source operand (two 32-bit lanes) |
| rs2 | input | 64 | Second source operand (two 32-bit lanes) |
| funct7 | input | 7 | Op select; also carries the rotation index |
| out_result | output | 64 | Registered lane-wise result |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_illegal | output | 1 | Unsupported funct7 seen on the previous request |

## Verification
Every result, flag and hold effect is due exactly one clock edge after the request. The bench drives inputs on the falling edge. The rising edge in between registers the result, and the bench samples on the next falling edge before it changes any input. For the hold check (R8), the bench deasserts `in_valid`, scrambles the operands and funct7, and samples one cycle later. The reset check samples one falling edge after a reset edge.

// File: rtl/chl_pkg.sv
package chl_pkg;
  localparam int LANE_W   = 32;
  localparam int LANES    = 2;
  localparam int F7_W     = 7;
  localparam int ADD_CODE = 24;
  localparam int NUM_ROT  = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_XRL = 2'd1,
    OP_BAD = 2'd2
  } op_e;

  // Rotation schedule of the quarter round, indexed by immediate-1.
  function automatic int unsigned rot_amount(input logic [1:0] idx);
    case (idx)
      2'd0:    return 16;
      2'd1:    return 12;
      2'd2:    return 8;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/chl_decode.sv
module chl_decode
  import chl_pkg::*;
#(
  parameter int F7_W     = chl_pkg::F7_W,
  parameter int ADD_CODE = chl_pkg::ADD_CODE,
  parameter int NUM_ROT  = chl_pkg::NUM_ROT
) (
  input  logic [F7_W-1:0] funct7,
  output op_e             op,
  output logic [1:0]      rot_idx
);
  localparam logic [F7_W-1:0] BASE = F7_W'(ADD_CODE);
  localparam logic [F7_W-1:0] LAST = F7_W'(ADD_CODE + NUM_ROT);

  logic [F7_W-1:0] offset;

  always_comb begin
    offset  = funct7 - BASE;
    rot_idx = 2'(offset - F7_W'(1));
    if (funct7 == BASE)
      op = OP_ADD;
    else if (funct7 > BASE && funct7 <= LAST)
      op = OP_XRL;
    else
      op = OP_BAD;
  end
endmodule

// File: rtl/chl_lane.sv
module chl_lane
  import chl_pkg::*;
#(
  parameter int W  = 32,
  parameter int RW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  op_e           op,
  input  logic [RW-1:0] rot,
  output logic [W-1:0]  y
);
  logic [W-1:0]  sum_w;
  logic [W-1:0]  mix_w;
  logic [W-1:0]  rol_w;
  logic [RW:0]   back_w;

  always_comb begin
    sum_w  = a + b;                 // W-bit wrap, no carry leaves the lane
    mix_w  = a ^ b;
    back_w = (RW+1)'(W) - {1'b0, rot};
    rol_w  = (mix_w << rot) | (mix_w >> back_w);
    case (op)
      OP_ADD:  y = sum_w;
      OP_XRL:  y = rol_w;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/chacha_lane_unit.sv
module chacha_lane_unit
  import chl_pkg::*;
#(
  parameter int LANE_W   = chl_pkg::LANE_W,
  parameter int LANES    = chl_pkg::LANES,
  parameter int F7_W     = chl_pkg::F7_W,
  parameter int ADD_CODE = chl_pkg::ADD_CODE
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [LANE_W*LANES-1:0] rs1,
  input  logic [LANE_W*LANES-1:0] rs2,
  input  logic [F7_W-1:0]         funct7,
  output logic [LANE_W*LANES-1:0] out_result,
  output logic                    out_valid,
  output logic                    out_illegal
);
  localparam int DW = LANE_W * LANES;
  localparam int RW = $clog2(LANE_W);

  op_e            op;
  logic [1:0]     rot_idx;
  logic [RW-1:0]  rot;
  logic [DW-1:0]  lanes_y;

  chl_decode #(.F7_W(F7_W), .ADD_CODE(ADD_CODE), .NUM_ROT(chl_pkg::NUM_ROT)) u_dec (
    .funct7 (funct7),
    .op     (op),
    .rot_idx(rot_idx)
  );

  assign rot = RW'(rot_amount(rot_idx));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    chl_lane #(.W(LANE_W), .RW(RW)) u_lane (
      .a  (rs1[g*LANE_W +: LANE_W]),
      .b  (rs2[g*LANE_W +: LANE_W]),
      .op (op),
      .rot(rot),
      .y  (lanes_y[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_result  <= '0;
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && (op == OP_BAD);
      if (in_valid)
        out_result <= lanes_y;
    end
  end
endmodule

// File: rtl/chl_checker.sv
module chl_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [63:0] rs1,
  input logic [63:0] rs2,
  input logic [6:0]  funct7,
  input logic [63:0] out_result,
  input logic        out_valid,
  input logic        out_illegal
);
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r6_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r5_bad_code: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (funct7 < 7'd24 || funct7 > 7'd28)) |=> (out_illegal && out_result == 64'd0));

  a_r1_low_sum: assert property (@(posedge clk) disable iff (rst)
    (in_valid && funct7 == 7'd24) |=>
      out_result[31:0] == 32'($past(rs1[31:0]) + $past(rs2[31:0])));

  a_r2_high_sum: assert property (@(posedge clk) disable iff (rst)
    (in_valid && funct7 == 7'd24) |=>
      out_result[63:32] == 32'($past(rs1[63:32]) + $past(rs2[63:32])));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && !out_illegal));

  a_r5_flag_needs_valid: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> out_valid);
endmodule

bind chacha_lane_unit chl_checker u_chl_checker (.*);

// File: tb/test_chacha_lane_unit.sv
module test_chacha_lane_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] rs1 = '0;
  logic [63:0] rs2 = '0;
  logic [6:0]  funct7 = '0;
  logic [63:0] out_result;
  logic        out_valid;
  logic        out_illegal;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;   // 50 MHz

  chacha_lane_unit i_chacha_lane_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rs1(rs1), .rs2(rs2),
    .funct7(funct7), .out_result(out_result), .out_valid(out_valid),
    .out_illegal(out_illegal)
  );

  localparam int NV = 10;
  // {rs1, rs2, funct7, expected}
  localparam logic [63:0] T_RS1 [NV] = '{
    64'h00000001_00000002, 64'h00000000_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF,
    64'h80000000_00000010, 64'h00000001_00001234, 64'hF0000000_00000001,
    64'h12345678_AAAAAAAA, 64'h80000000_00000003, 64'hFFFF0000_0000FFFF,
    64'h01000000_00000000};
  localparam logic [63:0] T_RS2 [NV] = '{
    64'h00000003_00000004, 64'h00000000_00000001, 64'h00000001_00000002,
    64'h80000000_00000020, 64'h00000000_00000000, 64'h00000000_00000000,
    64'h12345678_55555555, 64'h00000000_00000000, 64'h00000000_00000000,
    64'h00000000_00000001};
  localparam logic [6:0] T_F7 [NV] = '{
    7'd24, 7'd24, 7'd24, 7'd24, 7'd25, 7'd26, 7'd27, 7'd28, 7'd25, 7'd28};
  localparam logic [63:0] T_EXP [NV] = '{
    64'h00000004_00000006, 64'h00000000_00000000, 64'h00000000_00000001,
    64'h00000000_00000030, 64'h00010000_12340000, 64'h00000F00_00001000,
    64'h00000000_FFFFFFFF, 64'h00000040_00000180, 64'h0000FFFF_FFFF0000,
    64'h80000000_00000080};
  localparam string T_REQ [NV] = '{
    "R1", "R2", "R2", "R2", "R3", "R3", "R4", "R3", "R4", "R4"};

  function automatic logic [31:0] m_rotl(input logic [31:0] x, input int n);
    logic [31:0] v = x;
    for (int i = 0; i < n; i++) v = {v[30:0], v[31]};
    return v;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [6:0] f);
    int n;
    logic [31:0] hi, lo;
    if (f == 7'd24) begin
      hi = a[63:32] + b[63:32];
      lo = a[31:0] + b[31:0];
    end else if (f >= 7'd25 && f <= 7'd28) begin
      n  = (f == 7'd25) ? 16 : (f == 7'd26) ? 12 : (f == 7'd27) ? 8 : 7;
      hi = m_rotl(a[63:32] ^ b[63:32], n);
      lo = m_rotl(a[31:0] ^ b[31:0], n);
    end else begin
      hi = '0;
      lo = '0;
    end
    return {hi, lo};
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive on a falling edge, sample on the next falling edge (one rising edge between).
  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [6:0] f);
    @(negedge clk);
    rs1 = a; rs2 = b; funct7 = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [63:0] a, b, held;
    // R7: reset state
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check1("R7", out_valid, 1'b0);
    check1("R7", out_illegal, 1'b0);
    check64("R7", out_result, 64'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      issue(T_RS1[i], T_RS2[i], T_F7[i]);
      check64(T_REQ[i], out_result, T_EXP[i]);
      check1("R6", out_valid, 1'b1);
      check1("R5", out_illegal, 1'b0);
    end

    // Sweep every legal code with pseudo-random operands (R1, R2, R3)
    a = 64'h9E3779B9_7F4A7C15;
    b = 64'hC2B2AE35_85EBCA6B;
    for (int k = 0; k < 5; k++) begin
      for (int j = 0; j < 6; j++) begin
        a = {a[62:0], a[63] ^ a[61] ^ a[60] ^ a[58]} ^ 64'h1;
        b = b * 64'd6364136223846793005 + 64'd1442695040888963407;
        issue(a, b, 7'(24 + k));
        check64(k == 0 ? "R1" : "R3", out_result, model(a, b, 7'(24 + k)));
      end
    end

    // R8: idle cycle keeps the result and leaves the flag low
    issue(64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 7'd24);
    held = out_result;
    check64("R2", held, 64'hFFFFFFFE_FFFFFFFE);
    rs1 = 64'h0123456789ABCDEF; rs2 = 64'hFEDCBA9876543210; funct7 = 7'd99;
    @(negedge clk);
    check64("R8", out_result, held);
    check1("R8", out_illegal, 1'b0);
    check1("R6", out_valid, 1'b0);

    // R5: codes outside 24..28
    foreach (T_F7[i]) begin end
    issue(64'h11111111_22222222, 64'h33333333_44444444, 7'd0);
    check1("R5", out_illegal, 1'b1);
    check64("R5", out_result, 64'd0);
    issue(64'h11111111_22222222, 64'h33333333_44444444, 7'd23);
    check1("R5", out_illegal, 1'b1);
    check64("R5", out_result, 64'd0);
    issue(64'h11111111_22222222, 64'h33333333_44444444, 7'd29);
    check1("R5", out_illegal, 1'b1);
    check64("R5", out_result, 64'd0);
    issue(64'h11111111_22222222, 64'h33333333_44444444, 7'd127);
    check1("R5", out_illegal, 1'b1);
    check1("R6", out_valid, 1'b1);
    // a legal request right after clears the flag
    issue(64'h00000000_00000005, 64'h00000000_00000007, 7'd24);
    check1("R5", out_illegal, 1'b0);
    check64("R1", out_result, 64'h00000000_0000000C);

    // R7: reset mid-stream
    @(negedge clk);
    rs1 = 64'h1; rs2 = 64'h1; funct7 = 7'd24; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check1("R7", out_valid, 1'b0);
    check64("R7", out_result, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule